// File: doc/BRIEF.md
# T1 Transmit Line Encoder

This block forms the digital transmit stream that feeds a T1 line driver. Two dual-rail sources, each with its own bit clock, arrive at its edge: a primary pair and a loopback pair. A select input picks one of them. The block samples the chosen rails on the falling edge of the chosen clock. It produces a pair of pulse enables, one for positive marks and one for negative marks, which the analog driver turns into line pulses.

The block runs on a fast system clock and oversamples the selected line clock to find each bit boundary. It detects unipolar NRZ input on its own: NRZ input is recognised when both rails are high in the same bit. In that case it builds an alternate-mark-inversion stream itself. Signed dual-rail input is passed through unchanged. On top of either kind of input, the block can substitute runs of eight zeros with the B8ZS pattern. It can also replace all traffic with an unframed all-ones alarm whose marks keep alternating. Every bit leaves the block a fixed eight bit periods after it was sampled, whether or not substitution is enabled.

The control inputs for loopback select, substitution enable and alarm are inactive when low. Tie them low when they are not used.

Top module: `t1_tx_encoder`

## Requirements
- R1: When `loop_sel` is 0, data comes from `pri_pos`/`pri_neg`, bit-timed by `pri_clk`. When it is 1, data comes from `lb_pos`/`lb_neg`, bit-timed by `lb_clk`. The rails of the unselected source have no effect on the outputs.
- R2: A bit is sampled on each falling edge of the selected line clock. `tx_pos`/`tx_neg` change at most once per bit period and hold steady between bit boundaries.
- R3: The bit sampled at falling edge k reaches the outputs at falling edge k+8 and holds there for that bit period. The same latency applies with substitution on or off.
- R4: In dual-rail mode with substitution off, each bit is copied to the outputs. Positive rail high gives `tx_pos`=1, negative rail high gives `tx_neg`=1, and both rails low gives no pulse.
- R5: A bit with both selected rails high puts the block into NRZ mode, starting with that bit itself.
- R6: NRZ mode ends after 32 consecutive bits that do not have both rails high. The 32nd such bit is still coded as NRZ; the 33rd is coded as dual-rail.
- R7: In NRZ mode a one (either rail high) is sent as a mark of the polarity opposite to the previous mark, and a zero is sent as no pulse. After reset the previous mark counts as negative, so the first mark coded this way is positive.
- R8: With `zcs_en` high, any eight consecutive zero bits in the outgoing stream are sent as 0,0,0,V,B,0,V,B in time order. V has the polarity of the mark sent just before it, and B has the opposite polarity. Later marks alternate from the last B.
- R9: With `zcs_en` low, runs of zeros of any length are sent as no pulse.
- R10: While `alarm_en` is high at a bit boundary, that bit is sent as a mark opposite to the previous mark, whatever the input. After the alarm is released, eight more alternating marks drain out before delayed input data resumes. No partial substitution appears.
- R11: `tx_pos` and `tx_neg` are never both 1.
- R12: While `rst_n` is low and after its release, both outputs are 0 until data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than the line bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_sel | input | 1 | 0 selects the primary source, 1 selects the loopback source |
| zcs_en | input | 1 | Enables B8ZS substitution of eight-zero runs |
| alarm_en | input | 1 | Replaces traffic with all-ones alarm marks |
| pri_clk | input | 1 | Primary source bit clock (sampled on its falling edge) |
| pri_pos | input | 1 | Primary positive rail |
| pri_neg | input | 1 | Primary negative rail |
| lb_clk | input | 1 | Loopback source bit clock |
| lb_pos | input | 1 | Loopback positive rail |
| lb_neg | input | 1 | Loopback negative rail |
| tx_pos | output | 1 | Positive pulse enable to the line driver |
| tx_neg | output | 1 | Negative pulse enable to the line driver |

## Verification
The properties assume the following about the inputs:
- Each half period of the selected line clock spans several system clocks, so every falling edge gives exactly one single-cycle bit strobe.
- The rails are stable for the synchroniser depth around that edge.
- The controls and the loopback select change only while the line clocks are low, so they never create a false edge.

The stimulus keeps within these limits. It holds each half bit for eight system clocks, changes the rails together with the rising line clock, and changes the controls in the low half of a bit, with both line clocks kept in phase.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;

  // Length of a zero run that B8ZS replaces; the substitution pattern is fixed to it.
  localparam int ZCS_RUN = 8;

  // Symbols held in the look-ahead window; polarity is resolved at emission.
  typedef enum logic [2:0] {
    SYM_ZERO  = 3'd0,  // no pulse
    SYM_AMI   = 3'd1,  // mark, opposite to the previous mark
    SYM_PLUS  = 3'd2,  // mark, forced positive
    SYM_MINUS = 3'd3,  // mark, forced negative
    SYM_VIOL  = 3'd4,  // mark, same as the previous mark
    SYM_BAL   = 3'd5   // mark, opposite to the previous mark (substitution)
  } sym_t;

  // Map one sampled rail pair to a symbol.
  function automatic sym_t classify(input logic p, input logic n, input logic nrz);
    if (nrz) return (p | n) ? SYM_AMI : SYM_ZERO;
    if (p) return SYM_PLUS;
    if (n) return SYM_MINUS;
    return SYM_ZERO;
  endfunction

  // Substitution content by window slot, slot 0 being the newest bit.
  function automatic sym_t zcs_slot(input int idx);
    case (idx)
      0, 3:    return SYM_BAL;
      1, 4:    return SYM_VIOL;
      default: return SYM_ZERO;
    endcase
  endfunction

  // Pulse pair {pos, neg} for a symbol given the polarity of the last mark.
  function automatic logic [1:0] emit_pair(input sym_t s, input logic last_pos);
    case (s)
      SYM_AMI, SYM_BAL: return {~last_pos, last_pos};
      SYM_VIOL:         return {last_pos, ~last_pos};
      SYM_PLUS:         return 2'b10;
      SYM_MINUS:        return 2'b01;
      default:          return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/t1tx_src_sel.sv
module t1tx_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_sel,
  input  logic pri_clk,
  input  logic pri_pos,
  input  logic pri_neg,
  input  logic lb_clk,
  input  logic lb_pos,
  input  logic lb_neg,
  output logic bit_stb,
  output logic bit_p,
  output logic bit_n
);

  localparam int CK_W = SYNC_STAGES + 1;

  logic raw_ck, raw_p, raw_n;
  logic [CK_W-1:0]        ck_q;
  logic [SYNC_STAGES-1:0] p_q, n_q;

  assign raw_ck = loop_sel ? lb_clk : pri_clk;
  assign raw_p  = loop_sel ? lb_pos : pri_pos;
  assign raw_n  = loop_sel ? lb_neg : pri_neg;

  // Rails travel alongside the clock so they stay aligned with its last stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      p_q  <= '0;
      n_q  <= '0;
    end else begin
      ck_q <= {ck_q[CK_W-2:0], raw_ck};
      p_q  <= {p_q[SYNC_STAGES-2:0], raw_p};
      n_q  <= {n_q[SYNC_STAGES-2:0], raw_n};
    end
  end

  // One-cycle strobe on the first low sample of the line clock.
  assign bit_stb = ck_q[CK_W-1] & ~ck_q[CK_W-2];
  assign bit_p   = p_q[SYNC_STAGES-1];
  assign bit_n   = n_q[SYNC_STAGES-1];

endmodule

// File: rtl/t1tx_nrz_det.sv
module t1tx_nrz_det #(
  parameter int HOLD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_p,
  input  logic bit_n,
  output logic coinc,
  output logic nrz_mode,
  output logic use_nrz
);

  localparam int CW = $clog2(HOLD);

  logic [CW-1:0] clean_q;

  assign coinc   = bit_stb & bit_p & bit_n;
  assign use_nrz = nrz_mode | (bit_p & bit_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrz_mode <= 1'b0;
      clean_q  <= '0;
    end else if (coinc) begin
      nrz_mode <= 1'b1;
      clean_q  <= '0;
    end else if (bit_stb && nrz_mode) begin
      if (clean_q == CW'(HOLD - 1)) begin
        nrz_mode <= 1'b0;
        clean_q  <= '0;
      end else begin
        clean_q <= clean_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/t1tx_line_coder.sv
module t1tx_line_coder
  import t1tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic zcs_en,
  input  logic alarm_en,
  input  sym_t sym_in,
  output logic tx_pos,
  output logic tx_neg
);

  sym_t win [ZCS_RUN];
  sym_t nxt [ZCS_RUN];
  logic run_zero;
  logic zcs_hit;
  logic last_pos;
  logic [1:0] pair_data, pair_ais;

  for (genvar g = 0; g < ZCS_RUN; g++) begin : g_shift
    if (g == 0) begin : g_head
      assign nxt[g] = sym_in;
    end else begin : g_body
      assign nxt[g] = win[g-1];
    end
  end

  always_comb begin
    run_zero = 1'b1;
    for (int i = 0; i < ZCS_RUN; i++) begin
      if (nxt[i] != SYM_ZERO) run_zero = 1'b0;
    end
  end

  assign zcs_hit   = bit_stb & zcs_en & ~alarm_en & run_zero;
  assign pair_data = emit_pair(win[ZCS_RUN-1], last_pos);
  assign pair_ais  = emit_pair(SYM_AMI, last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ZCS_RUN; i++) win[i] <= SYM_ZERO;
      tx_pos   <= 1'b0;
      tx_neg   <= 1'b0;
      last_pos <= 1'b0;
    end else if (bit_stb) begin
      if (alarm_en) begin
        for (int i = 0; i < ZCS_RUN; i++) win[i] <= SYM_AMI;
        {tx_pos, tx_neg} <= pair_ais;
        last_pos         <= pair_ais[1];
      end else begin
        for (int i = 0; i < ZCS_RUN; i++) win[i] <= zcs_hit ? zcs_slot(i) : nxt[i];
        {tx_pos, tx_neg} <= pair_data;
        if (|pair_data) last_pos <= pair_data[1];
      end
    end
  end

endmodule

// File: rtl/t1_tx_encoder.sv
module t1_tx_encoder
  import t1tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NRZ_HOLD    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_sel,
  input  logic zcs_en,
  input  logic alarm_en,
  input  logic pri_clk,
  input  logic pri_pos,
  input  logic pri_neg,
  input  logic lb_clk,
  input  logic lb_pos,
  input  logic lb_neg,
  output logic tx_pos,
  output logic tx_neg
);

  logic bit_stb, bit_p, bit_n;
  logic coinc, nrz_mode, use_nrz;
  sym_t sym;

  t1tx_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_sel(loop_sel),
    .pri_clk (pri_clk),
    .pri_pos (pri_pos),
    .pri_neg (pri_neg),
    .lb_clk  (lb_clk),
    .lb_pos  (lb_pos),
    .lb_neg  (lb_neg),
    .bit_stb (bit_stb),
    .bit_p   (bit_p),
    .bit_n   (bit_n)
  );

  t1tx_nrz_det #(.HOLD(NRZ_HOLD)) u_nrz (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .bit_p   (bit_p),
    .bit_n   (bit_n),
    .coinc   (coinc),
    .nrz_mode(nrz_mode),
    .use_nrz (use_nrz)
  );

  assign sym = classify(bit_p, bit_n, use_nrz);

  t1tx_line_coder u_coder (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .zcs_en  (zcs_en),
    .alarm_en(alarm_en),
    .sym_in  (sym),
    .tx_pos  (tx_pos),
    .tx_neg  (tx_neg)
  );

endmodule

// File: rtl/t1_tx_encoder_chk.sv
module t1_tx_encoder_chk
  import t1tx_pkg::*;
#(
  parameter int NRZ_HOLD = 32
) (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic coinc,
  input logic nrz_mode,
  input logic zcs_en,
  input logic alarm_en,
  input logic tx_pos,
  input logic tx_neg
);

  localparam int CW      = $clog2(NRZ_HOLD + 1);
  localparam int AGE_MAX = 2 * ZCS_RUN;

  logic          stb_q;
  logic          mark_pos, seen_mark;
  logic [CW-1:0] clean_cnt;
  logic [4:0]    en_age;
  logic [3:0]    zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      mark_pos  <= 1'b0;
      seen_mark <= 1'b0;
      clean_cnt <= CW'(NRZ_HOLD);
      en_age    <= '0;
      zrun      <= '0;
    end else begin
      stb_q <= bit_stb;
      if (stb_q) begin
        if (tx_pos || tx_neg) begin
          mark_pos  <= tx_pos;
          seen_mark <= 1'b1;
          zrun      <= '0;
        end else if (zrun < 4'(ZCS_RUN)) begin
          zrun <= zrun + 1'b1;
        end
      end
      if (bit_stb) begin
        if (coinc) clean_cnt <= '0;
        else if (clean_cnt < CW'(NRZ_HOLD)) clean_cnt <= clean_cnt + 1'b1;
        if (!zcs_en) en_age <= '0;
        else if (en_age < 5'(AGE_MAX)) en_age <= en_age + 1'b1;
      end
    end
  end

  // R11
  both_low_or_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pos && tx_neg));

  // R2
  hold_between_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable({tx_pos, tx_neg}));

  // R10
  alarm_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && alarm_en) |=> (tx_pos || tx_neg));

  // R10
  alarm_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && alarm_en && seen_mark) |=> (tx_pos == !mark_pos));

  // R5
  nrz_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && coinc) |=> nrz_mode);

  // R6
  nrz_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_mode == (clean_cnt < CW'(NRZ_HOLD)));

  // R8
  zero_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_age == 5'(AGE_MAX)) |-> (zrun < 4'(ZCS_RUN)));

endmodule

bind t1_tx_encoder t1_tx_encoder_chk #(.NRZ_HOLD(NRZ_HOLD)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_stb (bit_stb),
  .coinc   (coinc),
  .nrz_mode(nrz_mode),
  .zcs_en  (zcs_en),
  .alarm_en(alarm_en),
  .tx_pos  (tx_pos),
  .tx_neg  (tx_neg)
);

// File: tb/test_t1_tx_encoder.sv
`timescale 1ns/1ps
module test_t1_tx_encoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_sel = 1'b0, zcs_en = 1'b0, alarm_en = 1'b0;
  logic pri_clk = 1'b1, pri_pos = 1'b0, pri_neg = 1'b0;
  logic lb_clk = 1'b1, lb_pos = 1'b0, lb_neg = 1'b0;
  logic tx_pos, tx_neg;

  always #5 clk = ~clk;

  t1_tx_encoder i_t1_tx_encoder (
    .clk(clk), .rst_n(rst_n), .loop_sel(loop_sel), .zcs_en(zcs_en),
    .alarm_en(alarm_en), .pri_clk(pri_clk), .pri_pos(pri_pos),
    .pri_neg(pri_neg), .lb_clk(lb_clk), .lb_pos(lb_pos), .lb_neg(lb_neg),
    .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R12";

  // Reference state: queue of pending symbols, oldest first.
  // Codes: 0 none, 1 alternate, 2 plus, 3 minus, 4 same-as-last, 5 opposite.
  int q[$];
  int nrz_on = 0;
  int clean = 0;
  bit prev_plus = 1'b0;
  bit [1:0] expect_out = 2'b00;

  task automatic chk(string req, bit [1:0] act, bit [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [1:0] pulse(int s);
    bit plus;
    if (s == 0) return 2'b00;
    case (s)
      2: plus = 1'b1;
      3: plus = 1'b0;
      4: plus = prev_plus;
      default: plus = !prev_plus;
    endcase
    prev_plus = plus;
    return plus ? 2'b10 : 2'b01;
  endfunction

  task automatic ref_bit(bit p, bit n);
    int s;
    int oldest;
    bit tied;
    bit zeros;
    tied = p && n;
    s = 0;
    if (nrz_on != 0 || tied) s = (p || n) ? 1 : 0;
    else if (p) s = 2;
    else if (n) s = 3;
    if (tied) begin
      nrz_on = 1;
      clean = 0;
    end else if (nrz_on != 0) begin
      clean++;
      if (clean == 32) begin
        nrz_on = 0;
        clean = 0;
      end
    end
    if (alarm_en) begin
      q.delete();
      for (int k = 0; k < 8; k++) q.push_back(1);
      expect_out = pulse(1);
    end else begin
      oldest = q.pop_front();
      q.push_back(s);
      zeros = 1'b1;
      foreach (q[k]) if (q[k] != 0) zeros = 1'b0;
      if (zcs_en && zeros) q = '{0, 0, 0, 4, 5, 0, 4, 5};
      expect_out = pulse(oldest);
    end
  endtask

  task automatic do_bit(bit tp, bit tn, bit lp, bit ln);
    pri_clk = 1'b1; lb_clk = 1'b1;
    pri_pos = tp; pri_neg = tn; lb_pos = lp; lb_neg = ln;
    repeat (8) @(negedge clk);
    chk("R2", {tx_pos, tx_neg}, expect_out);
    pri_clk = 1'b0; lb_clk = 1'b0;
    if (loop_sel) ref_bit(lp, ln);
    else ref_bit(tp, tn);
    repeat (8) @(negedge clk);
    chk(tag, {tx_pos, tx_neg}, expect_out);
    chk("R11", {1'b0, tx_pos & tx_neg}, 2'b00);
  endtask

  task automatic dual(int kind);
    do_bit(kind == 1, kind == 2, $urandom_range(1, 0) != 0, $urandom_range(1, 0) != 0);
  endtask

  task automatic zeros_n(int n);
    for (int k = 0; k < n; k++) dual(0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) q.push_back(0);
    repeat (4) @(negedge clk);
    chk("R12", {tx_pos, tx_neg}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", {tx_pos, tx_neg}, 2'b00);

    tag = "R4";
    for (int k = 0; k < 40; k++) dual($urandom_range(2, 0));

    tag = "R3";
    zeros_n(12); dual(1); zeros_n(12);

    tag = "R5";
    do_bit(1, 1, 0, 0);
    tag = "R7";
    for (int k = 0; k < 40; k++) begin
      automatic bit b = $urandom_range(1, 0) != 0;
      do_bit(b, b, 0, 0);
    end

    tag = "R6";
    do_bit(1, 1, 0, 0);
    for (int k = 0; k < 31; k++) do_bit(0, 0, 1, 1);
    do_bit(0, 1, 0, 0);
    do_bit(0, 1, 0, 0);
    do_bit(1, 0, 0, 0);
    zeros_n(10);

    tag = "R8";
    zcs_en = 1'b1;
    dual(1); zeros_n(8); dual(2); zeros_n(10); dual(1); zeros_n(16);
    dual(2); zeros_n(7); dual(1); zeros_n(9);
    for (int k = 0; k < 30; k++) begin
      automatic bit b = ($urandom_range(3, 0) == 0);
      do_bit(b, b, 0, 0);
    end
    zeros_n(12);

    tag = "R9";
    zcs_en = 1'b0;
    dual(1); zeros_n(14);

    tag = "R1";
    loop_sel = 1'b1;
    for (int k = 0; k < 30; k++) begin
      automatic int r = $urandom_range(2, 0);
      do_bit($urandom_range(1, 0) != 0, $urandom_range(1, 0) != 0, r == 1, r == 2);
    end
    zeros_n(10);
    loop_sel = 1'b0;

    tag = "R10";
    zcs_en = 1'b1;
    dual(1); zeros_n(5);
    alarm_en = 1'b1;
    for (int k = 0; k < 12; k++) dual($urandom_range(2, 0));
    alarm_en = 1'b0;
    for (int k = 0; k < 16; k++) dual($urandom_range(2, 0));
    zeros_n(10);

    finish_run();
  end

endmodule